// File: doc/BRIEF.md
# Cache Line Zeroing Unit

This unit carries out a "zero one cache block" command. A command carries an effective address, the opcode word of the instruction that issued it, and an address-space tag. The unit rounds the address down to the start of its cache line and then fills the whole line with zeros. It does this as a run of 64-bit stores on a valid/ready store port. The stores go out at ascending 8-byte offsets from the line base. Each store carries the address-space tag that came with the command, so that a following translation stage can pick either the normal data space or the alternate external-process space.

The line size is chosen at run time. Normally it is the `LINE_BYTES` parameter, a power of two from 32 to 128 bytes. When the legacy input is set, opcode bit 21 is clear and bits [8:7] of the configuration word read binary 01, the line shrinks to 32 bytes. The opcode bit and the field positions are parameters.

The unit also holds the single load-reserve reservation address. A load-reserve stage writes it through a set port. When a zeroing command is accepted and the stored reservation falls inside the line being cleared, the reservation is made invalid, which means it is written to all ones. This check uses the same effective line size as the stores. A completion pulse follows the last accepted store.

Top module: `lineZeroUnit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cmdReady` is 1, `stValid` is 0, `done` is 0 and `rsvAddr` is all ones.
- R2: The first store of a command goes to `cmdAddr` with its low log2(size) bits cleared, where size is the effective line size of R4.
- R3: A command issues exactly size/8 stores, each with `stData` equal to zero. Store k (counted from 0) goes to base + 8·k. While `stValid` is 1 and `stReady` is 0, `stValid` stays 1 and `stAddr` holds its value.
- R4: The effective line size is 32 bytes when `legacyEn` is 1, `cmdOpcode` bit 21 is 0 and `cfgWord[8:7]` equals 2'b01. In every other case it is `LINE_BYTES`.
- R5: On the clock edge that accepts a command (`cmdValid` and `cmdReady` both 1), if `rsvAddr` masked to the effective line size equals the aligned base, `rsvAddr` becomes all ones. Otherwise it keeps its value. The result is visible in the next cycle.
- R6: When `rsvSet` is 1, the next value of `rsvAddr` is `rsvSetAddr`. This holds even if a reservation kill from R5 happens on the same edge.
- R7: Every store of a command carries, on `stAltSpace`, the value that `cmdAltSpace` had when the command was accepted.
- R8: `cmdReady` is 0 from the cycle after acceptance until the last store is acknowledged. `done` is high for exactly one cycle, the cycle right after the last store handshake, and `cmdReady` is 1 again in that cycle.
- R9: A `cmdValid` that arrives while a command is in progress is not accepted, and it changes neither the store sequence nor its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A zeroing command is offered |
| cmdReady | output | 1 | Unit is idle and takes a command |
| cmdAddr | input | ADDR_W | Effective address of the command |
| cmdOpcode | input | OPC_W | Opcode word of the issuing instruction |
| cmdAltSpace | input | 1 | Use the alternate store address space |
| legacyEn | input | 1 | Core runs the legacy line-size model |
| cfgWord | input | CFG_W | Configuration word holding the size field |
| rsvSet | input | 1 | Load the reservation address |
| rsvSetAddr | input | ADDR_W | New reservation address |
| rsvAddr | output | ADDR_W | Current reservation, all ones when invalid |
| stValid | output | 1 | A store is offered |
| stReady | input | 1 | Store port takes the store |
| stAddr | output | ADDR_W | Store address, 8-byte aligned |
| stData | output | 64 | Store data, always zero |
| stAltSpace | output | 1 | Address-space tag of the store |
| done | output | 1 | One-cycle pulse after the last store is acknowledged |

## Verification
The bench sweeps all sixteen combinations of the legacy input, opcode bit 21 and the two-bit configuration field, and runs several addresses for each combination.

- **Wrong line-size decode.** A design that decodes the field wrongly, or ignores the opcode bit, issues 4 stores where 8 are expected, or 8 where 4 are expected. It also misaligns the base address.
- **Wrong reservation mask.** Some reservations differ from the command address only in bit 5. With a 64-byte line such a reservation must be killed; with a 32-byte line it must survive. A design that compares with a fixed mask, or with the wrong mask, gets one of these two cases wrong.
- **Set and kill on the same edge.** A reservation set that lands on the accept edge must win over the kill.
- **Store-port stalls.** Stalls are placed at varying beats. Stray commands are offered while the unit is busy. A design that advances on a stall, or restarts on a stray command, shows skipped or repeated addresses, or an early `done`.

// File: rtl/lineZeroPkg.sv
package lineZeroPkg;
  localparam int STORE_BYTES = 8;
  localparam int STORE_W     = 8 * STORE_BYTES;

  typedef enum logic [0:0] {
    ZS_IDLE = 1'b0,
    ZS_BUSY = 1'b1
  } zeroState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // command accepted this cycle
    logic step;   // store handshake this cycle
  } zeroStrobes_t;
endpackage

// File: rtl/lineZeroSize.sv
module lineZeroSize #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int OPC_W      = 32,
  parameter int CFG_W      = 16,
  parameter int LEGACY_BIT = 21,
  parameter int CFG_LSB    = 7,
  parameter int OFF_W      = $clog2(LINE_BYTES) + 1
) (
  input  logic              legacyEn,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [CFG_W-1:0]  cfgWord,
  output logic [OFF_W-1:0]  lineBytes,
  output logic [ADDR_W-1:0] lineMask
);
  localparam int LEGACY_BYTES = 32;

  logic useLegacy;
  logic unusedOpcCfg;

  assign unusedOpcCfg = ^{opcode, cfgWord};

  generate
    if (LINE_BYTES > LEGACY_BYTES) begin : g_legacy
      assign useLegacy = legacyEn && !opcode[LEGACY_BIT]
                         && (cfgWord[CFG_LSB +: 2] == 2'b01);
    end else begin : g_fixed
      // legacy size equals configured size: nothing to select
      assign useLegacy = 1'b0;
    end
  endgenerate

  always_comb begin
    lineBytes = useLegacy ? OFF_W'(LEGACY_BYTES) : OFF_W'(LINE_BYTES);
    lineMask  = ~({{(ADDR_W-OFF_W){1'b0}}, lineBytes} - ADDR_W'(1));
  end
endmodule

// File: rtl/lineZeroCtrl.sv
module lineZeroCtrl
  import lineZeroPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         stReady,
  input  logic         lastBeat,
  output logic         cmdReady,
  output logic         stValid,
  output logic         done,
  output zeroStrobes_t strobes
);
  zeroState_t stateQ, stateD;
  logic       doneQ;

  assign cmdReady     = (stateQ == ZS_IDLE);
  assign stValid      = (stateQ == ZS_BUSY);
  assign strobes.load = cmdValid && cmdReady;
  assign strobes.step = stValid && stReady;
  assign done         = doneQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ZS_IDLE: if (strobes.load) stateD = ZS_BUSY;
      ZS_BUSY: if (strobes.step && lastBeat) stateD = ZS_IDLE;
      default: stateD = ZS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ZS_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strobes.step && lastBeat;
    end
  end
endmodule

// File: rtl/lineZeroPath.sv
module lineZeroPath
  import lineZeroPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  zeroStrobes_t      strobes,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdAltSpace,
  input  logic [OFF_W-1:0]  lineBytes,
  input  logic [ADDR_W-1:0] lineMask,
  input  logic              rsvSet,
  input  logic [ADDR_W-1:0] rsvSetAddr,
  output logic [ADDR_W-1:0] stAddr,
  output logic              stAltSpace,
  output logic [ADDR_W-1:0] rsvAddr,
  output logic              lastBeat
);
  logic [ADDR_W-1:0] baseQ;
  logic [OFF_W-1:0]  offQ;
  logic [OFF_W-1:0]  sizeQ;
  logic              altQ;
  logic [ADDR_W-1:0] rsvQ;
  logic [ADDR_W-1:0] alignedCmd;
  logic              killHit;

  assign alignedCmd = cmdAddr & lineMask;
  assign killHit    = strobes.load && ((rsvQ & lineMask) == alignedCmd);
  assign lastBeat   = (offQ + OFF_W'(STORE_BYTES)) == sizeQ;
  assign stAddr     = baseQ + {{(ADDR_W-OFF_W){1'b0}}, offQ};
  assign stAltSpace = altQ;
  assign rsvAddr    = rsvQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
      sizeQ <= '0;
      altQ  <= 1'b0;
    end else if (strobes.load) begin
      baseQ <= alignedCmd;
      offQ  <= '0;
      sizeQ <= lineBytes;
      altQ  <= cmdAltSpace;
    end else if (strobes.step) begin
      offQ  <= offQ + OFF_W'(STORE_BYTES);
    end
  end

  // reservation register: a new set wins over a kill on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)        rsvQ <= '1;
    else if (rsvSet)  rsvQ <= rsvSetAddr;
    else if (killHit) rsvQ <= '1;
  end
endmodule

// File: rtl/lineZeroUnit.sv
module lineZeroUnit
  import lineZeroPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int OPC_W      = 32,
  parameter int CFG_W      = 16,
  parameter int LEGACY_BIT = 21,
  parameter int CFG_LSB    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [OPC_W-1:0]  cmdOpcode,
  input  logic              cmdAltSpace,
  input  logic              legacyEn,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              rsvSet,
  input  logic [ADDR_W-1:0] rsvSetAddr,
  output logic [ADDR_W-1:0] rsvAddr,
  output logic              stValid,
  input  logic              stReady,
  output logic [ADDR_W-1:0] stAddr,
  output logic [63:0]       stData,
  output logic              stAltSpace,
  output logic              done
);
  localparam int OFF_W = $clog2(LINE_BYTES) + 1;

  zeroStrobes_t      strobes;
  logic [OFF_W-1:0]  lineBytes;
  logic [ADDR_W-1:0] lineMask;
  logic              lastBeat;

  assign stData = '0;

  lineZeroSize #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .OPC_W(OPC_W), .CFG_W(CFG_W),
    .LEGACY_BIT(LEGACY_BIT), .CFG_LSB(CFG_LSB), .OFF_W(OFF_W)
  ) size_i (
    .legacyEn(legacyEn), .opcode(cmdOpcode), .cfgWord(cfgWord),
    .lineBytes(lineBytes), .lineMask(lineMask)
  );

  lineZeroCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .stReady(stReady),
    .lastBeat(lastBeat), .cmdReady(cmdReady), .stValid(stValid),
    .done(done), .strobes(strobes)
  );

  lineZeroPath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdAddr(cmdAddr),
    .cmdAltSpace(cmdAltSpace), .lineBytes(lineBytes), .lineMask(lineMask),
    .rsvSet(rsvSet), .rsvSetAddr(rsvSetAddr), .stAddr(stAddr),
    .stAltSpace(stAltSpace), .rsvAddr(rsvAddr), .lastBeat(lastBeat)
  );
endmodule

// File: rtl/lineZeroChk.sv
module lineZeroChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              rsvSet,
  input logic [ADDR_W-1:0] rsvSetAddr,
  input logic [ADDR_W-1:0] rsvAddr,
  input logic              stValid,
  input logic              stReady,
  input logic [ADDR_W-1:0] stAddr,
  input logic              stAltSpace,
  input logic              done
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid && !stReady |=> stValid && $stable(stAddr));

  // R2
  store_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |-> stAddr[2:0] == 3'b000);

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && stValid));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_after_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(stValid && stReady) && cmdReady);

  // R6
  rsv_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rsvSet |=> rsvAddr == $past(rsvSetAddr));

  // R7
  space_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid && $past(stValid) |-> $stable(stAltSpace));
endmodule

bind lineZeroUnit lineZeroChk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .rsvSet(rsvSet),
  .rsvSetAddr(rsvSetAddr), .rsvAddr(rsvAddr), .stValid(stValid),
  .stReady(stReady), .stAddr(stAddr), .stAltSpace(stAltSpace), .done(done)
);

// File: tb/lineZeroUnit_tb_top.sv
module lineZeroUnit_tb_top;
  localparam int AW = 32;
  localparam int LB = 64;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cmdValid, cmdReady, cmdAltSpace, legacyEn;
  logic [AW-1:0] cmdAddr;
  logic [31:0]   cmdOpcode;
  logic [15:0]   cfgWord;
  logic          rsvSet;
  logic [AW-1:0] rsvSetAddr, rsvAddr;
  logic          stValid, stReady, stAltSpace, done;
  logic [AW-1:0] stAddr;
  logic [63:0]   stData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lineZeroUnit #(.ADDR_W(AW), .LINE_BYTES(LB)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdOpcode(cmdOpcode), .cmdAltSpace(cmdAltSpace),
    .legacyEn(legacyEn), .cfgWord(cfgWord), .rsvSet(rsvSet),
    .rsvSetAddr(rsvSetAddr), .rsvAddr(rsvAddr), .stValid(stValid),
    .stReady(stReady), .stAddr(stAddr), .stData(stData),
    .stAltSpace(stAltSpace), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int effSize(input bit leg, input logic [31:0] opc, input logic [15:0] cfg);
    // R4
    return (leg && !opc[21] && cfg[8:7] == 2'b01) ? 32 : LB;
  endfunction

  task automatic runCmd(input logic [AW-1:0] addr, input logic [31:0] opc,
                        input bit alt, input bit leg, input logic [15:0] cfg,
                        input logic [AW-1:0] rsvPre, input bit junk, input int seed,
                        input bit setAtAccept, input logic [AW-1:0] lateRsv);
    int sz, nb;
    logic [AW-1:0] mask, base, expRsv, held;
    sz = effSize(leg, opc, cfg);
    nb = sz / 8;
    mask = ~(AW'(sz) - AW'(1));
    base = addr & mask;
    expRsv = ((rsvPre & mask) == base) ? '1 : rsvPre;
    if (setAtAccept) expRsv = lateRsv;
    // preload reservation
    @(negedge clk);
    rsvSet = 1'b1; rsvSetAddr = rsvPre;
    @(posedge clk); @(negedge clk);
    rsvSet = 1'b0;
    chk("R6 preload", rsvAddr, rsvPre);
    chk("R8 idle ready", cmdReady, 1);
    cmdValid = 1'b1; cmdAddr = addr; cmdOpcode = opc; cmdAltSpace = alt;
    legacyEn = leg; cfgWord = cfg;
    rsvSet = setAtAccept; rsvSetAddr = lateRsv;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0; rsvSet = 1'b0;
    chk(setAtAccept ? "R6 set beats kill" : "R5 reservation", rsvAddr, expRsv);
    for (int k = 0; k < nb; k++) begin
      cmdValid = junk && (k != nb - 1);
      cmdAddr = ~addr; cmdAltSpace = ~alt; cmdOpcode = ~opc;
      chk(junk ? "R9 busy ready" : "R8 busy ready", cmdReady, 0);
      chk("R3 valid", stValid, 1);
      if (k == 0) chk("R2 base", stAddr, base);
      chk(junk ? "R9 addr" : "R3 addr", stAddr, base + AW'(8 * k));
      chk("R3 zero", stData, 64'd0);
      chk("R7 space", stAltSpace, alt);
      if ((k + seed) % 3 == 0) begin
        held = stAddr;
        stReady = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R3 stall valid", stValid, 1);
        chk("R3 stall hold", stAddr, held);
      end
      stReady = 1'b1;
      @(posedge clk); @(negedge clk);
      stReady = 1'b0;
      if (k != nb - 1) chk("R8 no early done", done, 0);
    end
    cmdValid = 1'b0;
    chk("R8 done", done, 1);
    chk("R4 store count", stValid, 0);
    chk("R8 ready at done", cmdReady, 1);
    @(negedge clk);
    chk("R8 done single", done, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdAddr = '0; cmdOpcode = '0; cmdAltSpace = 1'b0;
    legacyEn = 1'b0; cfgWord = '0; rsvSet = 1'b0; rsvSetAddr = '0; stReady = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready", cmdReady, 1);
    chk("R1 valid", stValid, 0);
    chk("R1 done", done, 0);
    chk("R1 rsv", rsvAddr, {AW{1'b1}});
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", rsvAddr, {AW{1'b1}});
    chk("R1 ready after release", cmdReady, 1);

    for (int combo = 0; combo < 16; combo++) begin
      for (int i = 0; i < 4; i++) begin
        logic [AW-1:0] a, r;
        logic [31:0] opc;
        logic [15:0] cfg;
        a = 32'h1000_0000 + AW'(combo * 32'h1234) + AW'(i * 32'h3B);
        case (i)
          0: r = a ^ 32'h4;
          1: r = a ^ 32'h20;
          2: r = a ^ 32'h40;
          default: r = a;
        endcase
        opc = 32'h7C00_07EC | (combo[1] ? 32'h0020_0000 : 32'h0);
        cfg = 16'hA455 & ~16'h0180;
        cfg[8:7] = combo[3:2];
        runCmd(a, opc, i[0], combo[0], cfg, r, i == 2, combo + i, 1'b0, '0);
      end
    end
    // set on the accept edge wins over a kill
    runCmd(32'h2000_0047, 32'h0, 1'b0, 1'b0, 16'h0, 32'h2000_0040, 1'b0, 1, 1'b1, 32'h5555_0000);
    runCmd(32'h2000_0047, 32'h0, 1'b1, 1'b1, 16'h0080, 32'h2000_0040, 1'b0, 2, 1'b1, 32'h2000_0048);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule